// File: doc/BRIEF.md
# RMII Receive Elasticity Buffer

This block sits at the receive output of a 10/100 Ethernet PHY, where the reduced media-independent interface (RMII) leaves the chip. Decoded receive nibbles and a carrier flag arrive in the clock recovered from the line. The block moves them through a small dual-clock FIFO and sends them out two bits at a time on `rxd`, timed by the local 50 MHz reference clock. Any frequency difference between the two clocks is absorbed by the fill level of the FIFO. A frame starts to leave only after the FIFO holds half its depth, so the slack is the same in both directions.

The output `crsDv` carries both carrier sense and data valid on a single wire. It rises when carrier is seen and stays high while the frame flows. Once carrier is gone but buffered nibbles remain, it goes low only on the first dibit of a nibble. From then on it alternates, low on each first dibit and high on each second dibit, until the FIFO is empty. A MAC can therefore recover both signals. `rate10` selects 10 Mb/s timing, in which every dibit is held for ten reference cycles. An underflow or overflow inside a frame raises `rxEr` until the frame has ended.

Top module: `rmii_rx_elastic`

## Requirements
- R1: While reset is asserted, `crsDv` is 0, `rxd` is 00 and `rxEr` is 0.
- R2: Each nibble leaves as two dibits, bits 1:0 first and then bits 3:2, and nibbles leave in the order they were written.
- R3: With `rate10` = 0, a new dibit appears on every reference clock cycle. With `rate10` = 1, each dibit, together with the `crsDv` value that goes with it, is held for 10 consecutive reference clock cycles.
- R4: `crsDv` goes high after carrier is seen, before any data is shown. While no data is shown, `rxd` reads 00 and `crsDv` stays high.
- R5: When carrier comes with no data (false carrier), `crsDv` stays high and `rxd` stays 00 for as long as the carrier lasts. `crsDv` is low again within 8 reference cycles after the carrier ends.
- R6: After carrier is lost, `crsDv` first goes low on the first dibit (bits 1:0) of a nibble. It is then low on every first dibit and high on every second dibit of each later nibble.
- R7: In the reference cycle after the last dibit of the drained FIFO, `crsDv` is low.
- R8: Output of a frame starts once half the FIFO depth (4 nibbles by default) is buffered, or at once if carrier has ended first. In a frame shorter than that, `crsDv` is therefore already low on the first dibit.
- R9: If the FIFO runs empty while carrier is still present, `rxEr` goes high. `crsDv` stays high with `rxd` at 00 until the FIFO has refilled. `rxEr` returns to 0 only in a cycle where `crsDv` is low, once the frame has ended.
- R10: A nibble written while the FIFO is full is dropped, and `rxEr` goes high for that frame.
- R11: When the write rate matches the output rate, `rxEr` stays 0 for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| wrClk | input | 1 | Recovered receive clock |
| nibValid | input | 1 | Write strobe for `nibData`, in the `wrClk` domain |
| nibData | input | 4 | Decoded receive nibble |
| carrierIn | input | 1 | Carrier present, in the `wrClk` domain |
| refClk | input | 1 | 50 MHz reference clock for all outputs |
| rate10 | input | 1 | 1 selects 10 Mb/s timing, 0 selects 100 Mb/s |
| rxd | output | 2 | Receive dibit |
| crsDv | output | 1 | Multiplexed carrier sense and data valid |
| rxEr | output | 1 | Frame error flag (FIFO underflow or overflow) |

## Verification
Inputs take two reference cycles to cross the synchronizers, so the bench does not predict the exact cycle in which a frame starts. It anchors each frame on the first nonzero dibit, which is guaranteed because the first nibble always has nonzero low bits. From that anchor, every later result is due at a fixed offset: dibit k lands k·H cycles later, where H is 1 or 10, and `crsDv` must be low exactly one cycle after the last dibit. The bench samples on falling edges at those offsets and checks every cycle inside a held dibit. Results that depend on crossing latency, such as the drop after a false carrier or the error flag, are checked against a bounded window instead.

// File: rtl/rmii_eb_pkg.sv
package rmii_eb_pkg;

  typedef enum logic [1:0] {
    EB_IDLE,
    EB_PRIME,
    EB_STREAM
  } ebState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // pop one nibble into the output register
    logic phase;     // 0: bits 1:0 on the wire, 1: bits 3:2
    logic showData;  // drive the held nibble instead of 00
  } ebStrobe_t;

endpackage

// File: rtl/rmii_eb_data.sv
module rmii_eb_data
  import rmii_eb_pkg::*;
#(
  parameter int DEPTH = 8  // nibbles, power of two, at least 4
) (
  input  logic       wrClk,
  input  logic       refClk,
  input  logic       rstN,
  input  logic       nibValid,
  input  logic [3:0] nibData,
  input  logic       carrierIn,
  input  ebStrobe_t  strobe,
  output logic [1:0] rxd,
  output logic       fifoEmpty,
  output logic       fifoAtMid,
  output logic       overflowSeen,
  output logic       carrierSeen
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int MID = DEPTH / 2;

  logic [3:0]    mem [DEPTH];
  logic [PW-1:0] wBin, wGray, rGraySyncA, rGraySyncB;
  logic [PW-1:0] rBin, rGray, wGraySyncA, wGraySyncB, wBinSeen, fill;
  logic          full, ovfW, ovfSyncA, carSyncA;
  logic [3:0]    curNib;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write side, recovered clock
  assign full = (wGray == {~rGraySyncB[PW-1 -: 2], rGraySyncB[PW-3:0]});

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin       <= '0;
      wGray      <= '0;
      rGraySyncA <= '0;
      rGraySyncB <= '0;
      ovfW       <= 1'b0;
    end else begin
      rGraySyncA <= rGray;
      rGraySyncB <= rGraySyncA;
      if (nibValid && !full) begin
        wBin  <= wBin + 1'b1;
        wGray <= toGray(wBin + 1'b1);
      end
      if (!carrierIn) ovfW <= 1'b0;
      else if (nibValid && full) ovfW <= 1'b1;
    end
  end

  always_ff @(posedge wrClk) begin
    if (nibValid && !full) mem[wBin[AW-1:0]] <= nibData;
  end

  // read side, reference clock
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      wGraySyncA   <= '0;
      wGraySyncB   <= '0;
      ovfSyncA     <= 1'b0;
      overflowSeen <= 1'b0;
      carSyncA     <= 1'b0;
      carrierSeen  <= 1'b0;
      rBin         <= '0;
      rGray        <= '0;
      curNib       <= '0;
    end else begin
      wGraySyncA   <= wGray;
      wGraySyncB   <= wGraySyncA;
      ovfSyncA     <= ovfW;
      overflowSeen <= ovfSyncA;
      carSyncA     <= carrierIn;
      carrierSeen  <= carSyncA;
      if (strobe.load) begin
        curNib <= mem[rBin[AW-1:0]];
        rBin   <= rBin + 1'b1;
        rGray  <= toGray(rBin + 1'b1);
      end
    end
  end

  assign wBinSeen  = fromGray(wGraySyncB);
  assign fill      = wBinSeen - rBin;
  assign fifoEmpty = (rGray == wGraySyncB);
  assign fifoAtMid = (fill >= PW'(MID));

  always_comb begin
    if (!strobe.showData) rxd = 2'b00;
    else if (strobe.phase) rxd = curNib[3:2];
    else rxd = curNib[1:0];
  end

endmodule

// File: rtl/rmii_eb_ctrl.sv
module rmii_eb_ctrl
  import rmii_eb_pkg::*;
#(
  parameter int SLOW_HOLD = 10  // reference cycles per dibit at 10 Mb/s
) (
  input  logic      refClk,
  input  logic      rstN,
  input  logic      rate10,
  input  logic      carrierSeen,
  input  logic      fifoEmpty,
  input  logic      fifoAtMid,
  input  logic      overflowSeen,
  output ebStrobe_t strobe,
  output logic      crsDv,
  output logic      rxEr,
  output logic      dibitLast,
  output logic      priming
);
  localparam int HW = $clog2(SLOW_HOLD);

  ebState_e      st;
  logic [HW-1:0] holdCnt, holdMax;
  logic          phase, carLost, err, nibbleEnd, startNib;

  assign holdMax   = rate10 ? HW'(SLOW_HOLD - 1) : '0;
  assign dibitLast = (holdCnt == '0);
  assign nibbleEnd = (st == EB_STREAM) && dibitLast && phase;
  assign startNib  = !fifoEmpty &&
                     (((st == EB_PRIME) && (fifoAtMid || !carrierSeen)) || nibbleEnd);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      st      <= EB_IDLE;
      holdCnt <= '0;
      phase   <= 1'b0;
      carLost <= 1'b0;
      err     <= 1'b0;
    end else begin
      err <= (st != EB_IDLE) && (err || overflowSeen);
      unique case (st)
        EB_IDLE: if (carrierSeen) st <= EB_PRIME;
        EB_PRIME: begin
          if (startNib) begin
            st      <= EB_STREAM;
            phase   <= 1'b0;
            holdCnt <= holdMax;
            carLost <= !carrierSeen;
          end else if (!carrierSeen && fifoEmpty) begin
            st  <= EB_IDLE;
            err <= 1'b0;
          end
        end
        EB_STREAM: begin
          if (!dibitLast) begin
            holdCnt <= holdCnt - 1'b1;
          end else if (!phase) begin
            phase   <= 1'b1;
            holdCnt <= holdMax;
          end else if (startNib) begin
            phase   <= 1'b0;
            holdCnt <= holdMax;
            carLost <= carLost || !carrierSeen;
          end else if (carrierSeen) begin
            st  <= EB_PRIME;  // ran dry inside the frame
            err <= 1'b1;
          end else begin
            st  <= EB_IDLE;
            err <= 1'b0;
          end
        end
        default: st <= EB_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      EB_PRIME:  crsDv = 1'b1;
      EB_STREAM: crsDv = carLost ? phase : 1'b1;
      default:   crsDv = 1'b0;
    endcase
  end

  assign strobe.load     = startNib;
  assign strobe.phase    = phase;
  assign strobe.showData = (st == EB_STREAM);
  assign rxEr            = err;
  assign priming         = (st == EB_PRIME);

endmodule

// File: rtl/rmii_rx_elastic.sv
module rmii_rx_elastic
  import rmii_eb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int SLOW_HOLD = 10
) (
  input  logic       rstN,
  input  logic       wrClk,
  input  logic       nibValid,
  input  logic [3:0] nibData,
  input  logic       carrierIn,
  input  logic       refClk,
  input  logic       rate10,
  output logic [1:0] rxd,
  output logic       crsDv,
  output logic       rxEr
);
  ebStrobe_t strobe;
  logic fifoEmpty, fifoAtMid, overflowSeen, carrierSeen;
  logic dibitLast, priming, streamOn, phaseNow;

  rmii_eb_data #(.DEPTH(DEPTH)) u_data (
    .wrClk(wrClk), .refClk(refClk), .rstN(rstN),
    .nibValid(nibValid), .nibData(nibData), .carrierIn(carrierIn),
    .strobe(strobe), .rxd(rxd), .fifoEmpty(fifoEmpty), .fifoAtMid(fifoAtMid),
    .overflowSeen(overflowSeen), .carrierSeen(carrierSeen)
  );

  rmii_eb_ctrl #(.SLOW_HOLD(SLOW_HOLD)) u_ctrl (
    .refClk(refClk), .rstN(rstN), .rate10(rate10),
    .carrierSeen(carrierSeen), .fifoEmpty(fifoEmpty), .fifoAtMid(fifoAtMid),
    .overflowSeen(overflowSeen), .strobe(strobe), .crsDv(crsDv), .rxEr(rxEr),
    .dibitLast(dibitLast), .priming(priming)
  );

  assign streamOn = strobe.showData;
  assign phaseNow = strobe.phase;

endmodule

module rmii_rx_elastic_chk (
  input logic       refClk,
  input logic       rstN,
  input logic [1:0] rxd,
  input logic       crsDv,
  input logic       rxEr,
  input logic       streamOn,
  input logic       phaseNow,
  input logic       dibitLast,
  input logic       priming
);
  AST_DIBIT_HELD: assert property (@(posedge refClk) disable iff (!rstN)
    streamOn && !dibitLast |=> $stable(rxd) && $stable(crsDv)); // R3

  AST_CRS_DROP_FIRST_DIBIT: assert property (@(posedge refClk) disable iff (!rstN)
    streamOn && $fell(crsDv) |-> !phaseNow); // R6

  AST_TOGGLE_RESUMES: assert property (@(posedge refClk) disable iff (!rstN)
    streamOn && !crsDv && !phaseNow && dibitLast |=> crsDv || !streamOn); // R6

  AST_PRIME_QUIET: assert property (@(posedge refClk) disable iff (!rstN)
    priming |-> crsDv && (rxd == 2'b00)); // R4

  AST_ERR_CLEARS_IDLE: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(rxEr) |-> !crsDv); // R9
endmodule

bind rmii_rx_elastic rmii_rx_elastic_chk u_chk (
  .refClk(refClk), .rstN(rstN), .rxd(rxd), .crsDv(crsDv), .rxEr(rxEr),
  .streamOn(streamOn), .phaseNow(phaseNow), .dibitLast(dibitLast), .priming(priming)
);

// File: tb/tb_rmii_rx_elastic.sv
module tb_rmii_rx_elastic;
  localparam int REF_PERIOD = 20;
  localparam int WR_PERIOD  = 40;
  localparam int SLOW_HOLD  = 10;

  logic       refClk = 1'b0, wrClk = 1'b0, rstN = 1'b0;
  logic       nibValid = 1'b0, carrierIn = 1'b0, rate10 = 1'b0;
  logic [3:0] nibData = 4'h0;
  logic [1:0] rxd;
  logic       crsDv, rxEr;

  int total = 0;
  int bad   = 0;
  logic [3:0] nib [64];

  rmii_rx_elastic dut (
    .rstN(rstN), .wrClk(wrClk), .nibValid(nibValid), .nibData(nibData),
    .carrierIn(carrierIn), .refClk(refClk), .rate10(rate10),
    .rxd(rxd), .crsDv(crsDv), .rxEr(rxEr)
  );

  always #(REF_PERIOD / 2) refClk = ~refClk;
  initial begin
    #7;
    forever #(WR_PERIOD / 2) wrClk = ~wrClk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expDibit(input int i);
    return int'((nib[i/2] >> (2 * (i % 2))) & 4'h3);
  endfunction

  task automatic makeFrame(input int len);
    for (int k = 0; k < len; k++) nib[k] = 4'($urandom % 16);
    nib[0][1:0] = 2'(1 + $urandom % 3);  // first dibit never 00
  endtask

  // writes len nibbles; slow spaces them 10 cycles apart
  task automatic drive(input int len, input bit slow, input int stallAt, input int stallLen);
    @(negedge wrClk);
    carrierIn = 1'b1;
    repeat (2) @(negedge wrClk);
    for (int k = 0; k < len; k++) begin
      if (k == stallAt) begin
        nibValid = 1'b0;
        repeat (stallLen / 2) @(negedge wrClk);
        @(negedge refClk);
        chk(crsDv == 1'b1 && rxd == 2'b00, "R9 crsDv high rxd 00 while dry",
            int'({crsDv, rxd}), 4);
        repeat (stallLen - stallLen / 2) @(negedge wrClk);
      end
      nibValid = 1'b1;
      nibData  = nib[k];
      @(negedge wrClk);
      if (slow) begin
        nibValid = 1'b0;
        repeat (SLOW_HOLD - 1) @(negedge wrClk);
      end
    end
    nibValid  = 1'b0;
    carrierIn = 1'b0;
  endtask

  task automatic monitorGood(input int len, input bit slow, output logic firstCrs);
    int hold, preErr, holdErr, mism, firstAct, firstExp, first0;
    bit errSeen, patOk;
    logic [1:0] dv [128];
    logic dc [128];
    hold = slow ? SLOW_HOLD : 1;
    preErr = 0; holdErr = 0; mism = 0; firstAct = 0; firstExp = 0; errSeen = 0;
    @(negedge refClk);
    while (crsDv !== 1'b1) @(negedge refClk);
    while (rxd == 2'b00) begin
      if (!crsDv) preErr++;
      @(negedge refClk);
    end
    for (int i = 0; i < 2 * len; i++) begin
      for (int h = 0; h < hold; h++) begin
        if (h == 0) begin
          dv[i] = rxd;
          dc[i] = crsDv;
        end else if (rxd != dv[i] || crsDv != dc[i]) holdErr++;
        if (rxEr) errSeen = 1'b1;
        @(negedge refClk);
      end
    end
    chk(crsDv == 1'b0, "R7 crsDv low after drain", int'(crsDv), 0);
    for (int i = 0; i < 2 * len; i++) begin
      if (int'(dv[i]) != expDibit(i)) begin
        if (mism == 0) begin
          firstAct = int'(dv[i]);
          firstExp = expDibit(i);
        end
        mism++;
      end
    end
    chk(mism == 0, "R2 R3 dibit stream", firstAct, firstExp);
    if (slow) chk(holdErr == 0, "R3 dibit held 10 cycles", holdErr, 0);
    chk(preErr == 0, "R4 crsDv high before data", preErr, 0);
    first0 = -1;
    for (int i = 0; i < 2 * len; i++) begin
      if (dc[i] == 1'b0) begin
        first0 = i;
        break;
      end
    end
    patOk = (first0 >= 0) && (first0 % 2 == 0);
    if (patOk) begin
      for (int i = first0; i < 2 * len; i++) if (dc[i] != 1'((i % 2))) patOk = 1'b0;
    end
    chk(patOk, "R6 crsDv toggle after carrier loss", first0, 0);
    chk(!errSeen, "R11 no error at matched rate", int'(errSeen), 0);
    firstCrs = dc[0];
  endtask

  task automatic monitorErr(input string tag);
    int lowRun;
    bit seen;
    lowRun = 0;
    seen = 1'b0;
    @(negedge refClk);
    while (crsDv !== 1'b1) @(negedge refClk);
    while (lowRun < 40) begin
      if (rxEr) seen = 1'b1;
      lowRun = crsDv ? 0 : lowRun + 1;
      @(negedge refClk);
    end
    chk(seen, tag, int'(seen), 1);
    chk(rxEr == 1'b0, "R9 error cleared after frame", int'(rxEr), 0);
  endtask

  task automatic goodFrame(input int len, input bit slow, output logic firstCrs);
    @(negedge refClk);
    rate10 = slow;
    makeFrame(len);
    fork
      drive(len, slow, -1, 0);
      monitorGood(len, slow, firstCrs);
    join
    repeat (20) @(negedge refClk);
  endtask

  initial begin
    repeat (150000) @(posedge refClk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic fc;
    int errCnt;
    void'($urandom(32'd1234));
    repeat (4) @(negedge refClk);
    chk(crsDv == 1'b0, "R1 crsDv in reset", int'(crsDv), 0);
    chk(rxd == 2'b00, "R1 rxd in reset", int'(rxd), 0);
    chk(rxEr == 1'b0, "R1 rxEr in reset", int'(rxEr), 0);
    rstN = 1'b1;
    repeat (4) @(negedge refClk);

    // R5 false carrier
    @(negedge wrClk);
    carrierIn = 1'b1;
    repeat (3) @(negedge wrClk);
    errCnt = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge refClk);
      if (!(crsDv == 1'b1 && rxd == 2'b00)) errCnt++;
    end
    chk(errCnt == 0, "R5 false carrier holds crsDv", errCnt, 0);
    @(negedge wrClk);
    carrierIn = 1'b0;
    repeat (8) @(negedge refClk);
    chk(crsDv == 1'b0, "R5 crsDv low after false carrier", int'(crsDv), 0);

    goodFrame(20, 1'b0, fc);
    goodFrame(12, 1'b1, fc);
    goodFrame(3, 1'b0, fc);
    chk(fc == 1'b0, "R8 short frame starts after carrier end", int'(fc), 0);
    goodFrame(2, 1'b1, fc);
    chk(fc == 1'b0, "R8 short slow frame", int'(fc), 0);

    // R9 underflow: stall writes while carrier stays up
    @(negedge refClk);
    rate10 = 1'b0;
    makeFrame(24);
    fork
      drive(24, 1'b0, 12, 16);
      monitorErr("R9 underflow raises rxEr");
    join

    // R10 overflow: full-rate writes against slow output
    @(negedge refClk);
    rate10 = 1'b1;
    makeFrame(20);
    fork
      drive(20, 1'b0, -1, 0);
      monitorErr("R10 overflow raises rxEr");
    join
    repeat (20) @(negedge refClk);

    for (int f = 0; f < 10; f++) begin
      goodFrame(6 + int'($urandom % 35), 1'($urandom % 2), fc);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule